// File: doc/BRIEF.md
# Count/Compare Timer Interrupt Unit

This block is a free-running match timer of the kind found in a processor's system-control register set. A count register steps by one on every cycle where the tick-enable input is high. Software loads a compare value. When an increment brings the count onto the compare value, the unit raises a timer interrupt and holds it.

The interrupt leaves on one of several interrupt lines. A small select register, written at run time, picks the line. The only way to acknowledge the interrupt is to write the compare register. A halt bit freezes the count, and while it is set no match can happen. An elaboration-time option decides whether a readable pending flag exists. Without the option, the flag reads as zero, but the interrupt line still works.

Top module: `tick_match_timer`

## Requirements
- R1: After reset, the count reads 0, the pending flag reads 0 and every interrupt line is low. The compare value, the halt bit and the line select are all 0 after reset.
- R2: When the halt bit is 0 and tick_en is high on a clock edge, the count increases by one. It wraps from 2^CNT_W-1 to 0.
- R3: While the halt bit is 1, the count keeps its value and cnt_rdata returns that held value. No match is raised, however many ticks arrive.
- R4: A count write loads cnt_wdata on that edge and overrides any tick in the same cycle. A count write never raises a match, even when the loaded value equals the compare value. Later matches are judged from the loaded value.
- R5: A match occurs when a tick moves the count onto the current compare value. On the same edge that updates the count, the selected interrupt line goes high and the pending flag goes to 1.
- R6: Once raised, the interrupt stays high through any number of further ticks, count writes and halts, until the compare register is written.
- R7: A compare write clears the pending flag and drops the interrupt on that edge. The write wins over a match that lands in the same cycle.
- R8: Line k (bit k of irq_lines) is the only line that can be high, where k is the line-select value. A select write moves an active interrupt to the new line on the edge of the write.
- R9: With the pending-flag option off (HAS_PEND_FLAG=0), pend_rdata always reads 0. The interrupt lines behave exactly as they do with the option on.
- R10: Matching is modulo 2^CNT_W. With the compare value at 0, a tick from count 2^CNT_W-1 wraps the count to 0 and raises the interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Count-advance strobe |
| cnt_wr | input | 1 | Count write enable |
| cnt_wdata | input | CNT_W | Count write value |
| cmp_wr | input | 1 | Compare write enable; also acknowledges the interrupt |
| cmp_wdata | input | CNT_W | Compare write value |
| halt_wr | input | 1 | Halt-bit write enable |
| halt_wdata | input | 1 | Halt-bit value; 1 freezes the count |
| sel_wr | input | 1 | Line-select write enable |
| sel_wdata | input | SEL_W | Line-select value |
| cnt_rdata | output | CNT_W | Current count |
| pend_rdata | output | 1 | Timer-pending flag |
| irq_lines | output | N_LINES | Interrupt lines; at most one is high |

## Verification
Every result is due exactly one clock edge after its stimulus, because all state sits in registers that outputs read directly. This covers the count value, the interrupt level and its line, and the pending flag. The bench drives inputs after the falling edge and advances its reference state on the rising edge. It compares every output at the following falling edge, so each check samples the first cycle in which the new value is due. Directed sequences place a match, an acknowledge and a select change on the same edge, to confirm the single-edge timing where the actions collide.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   localparam int unsigned TMR_CNT_W_DEF = 32;
   localparam int unsigned TMR_LINES_DEF = 8;

   typedef enum logic [1:0] {
      CNT_HOLD = 2'd0,
      CNT_STEP = 2'd1,
      CNT_LOAD = 2'd2
   } cnt_op_e;
endpackage

// File: rtl/tmr_counter.sv
module tmr_counter
   import tmr_pkg::*;
#(
   parameter int unsigned CNT_W = TMR_CNT_W_DEF
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en,
   input  logic             ld,
   input  logic [CNT_W-1:0] ld_val,
   input  logic             halt_wr,
   input  logic             halt_wdata,
   output logic [CNT_W-1:0] cnt_q,
   output logic [CNT_W-1:0] cnt_inc,
   output logic             step
);
   localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   logic    halt_q;
   cnt_op_e op;

   assign cnt_inc = cnt_q + ONE;

   always_comb begin
      if (ld)                    op = CNT_LOAD;
      else if (tick_en && !halt_q) op = CNT_STEP;
      else                       op = CNT_HOLD;
   end

   assign step = (op == CNT_STEP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         halt_q <= 1'b0;
      end else begin
         if (halt_wr) halt_q <= halt_wdata;
         case (op)
            CNT_LOAD: cnt_q <= ld_val;
            CNT_STEP: cnt_q <= cnt_inc;
            default:  cnt_q <= cnt_q;
         endcase
      end
   end

   assert_halt_freezes_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $past(halt_q) && !$past(ld) |-> cnt_q == $past(cnt_q));

   assert_step_by_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $past(tick_en) && !$past(halt_q) && !$past(ld) |-> cnt_q == $past(cnt_q) + ONE);

   assert_load_value_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $past(ld) |-> cnt_q == $past(ld_val));
endmodule

// File: rtl/tmr_match.sv
module tmr_match
   import tmr_pkg::*;
#(
   parameter int unsigned CNT_W         = TMR_CNT_W_DEF,
   parameter bit          HAS_PEND_FLAG = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   input  logic [CNT_W-1:0] cnt_inc,
   input  logic             cmp_wr,
   input  logic [CNT_W-1:0] cmp_wdata,
   output logic             act_q,
   output logic             pend_o
);
   logic [CNT_W-1:0] cmp_q;
   logic             hit;

   assign hit = step && (cnt_inc == cmp_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmp_q <= '0;
         act_q <= 1'b0;
      end else begin
         if (cmp_wr) begin
            cmp_q <= cmp_wdata;
            act_q <= 1'b0;
         end else if (hit) begin
            act_q <= 1'b1;
         end
      end
   end

   if (HAS_PEND_FLAG) begin : g_pend
      assign pend_o = act_q;
   end else begin : g_nopend
      assign pend_o = 1'b0;
   end

   assert_ack_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $past(cmp_wr) |-> !act_q);

   assert_level_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $past(act_q) && !$past(cmp_wr) |-> act_q);

   assert_raise_only_on_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(act_q) |-> $past(step));
endmodule

// File: rtl/tmr_route.sv
module tmr_route
   import tmr_pkg::*;
#(
   parameter int unsigned N_LINES = TMR_LINES_DEF,
   parameter int unsigned SEL_W   = $clog2(N_LINES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sel_wr,
   input  logic [SEL_W-1:0]   sel_wdata,
   input  logic               act,
   output logic [N_LINES-1:0] lines
);
   logic [SEL_W-1:0] sel_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      sel_q <= '0;
      else if (sel_wr) sel_q <= sel_wdata;
   end

   for (genvar i = 0; i < N_LINES; i++) begin : g_line
      assign lines[i] = act && (sel_q == SEL_W'(i));
   end

   assert_single_line_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(lines));

   assert_moves_on_select_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $past(sel_wr) && act |-> lines[$past(sel_wdata)]);
endmodule

// File: rtl/tick_match_timer.sv
module tick_match_timer
   import tmr_pkg::*;
#(
   parameter int unsigned CNT_W         = TMR_CNT_W_DEF,
   parameter int unsigned N_LINES       = TMR_LINES_DEF,
   parameter bit          HAS_PEND_FLAG = 1'b1,
   localparam int unsigned SEL_W        = $clog2(N_LINES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tick_en,
   input  logic               cnt_wr,
   input  logic [CNT_W-1:0]   cnt_wdata,
   input  logic               cmp_wr,
   input  logic [CNT_W-1:0]   cmp_wdata,
   input  logic               halt_wr,
   input  logic               halt_wdata,
   input  logic               sel_wr,
   input  logic [SEL_W-1:0]   sel_wdata,
   output logic [CNT_W-1:0]   cnt_rdata,
   output logic               pend_rdata,
   output logic [N_LINES-1:0] irq_lines
);
   if (CNT_W < 2 || CNT_W > 64) begin : g_bad_width
      $error("tick_match_timer: CNT_W must lie in 2..64");
   end
   if (N_LINES < 2 || (1 << SEL_W) != N_LINES) begin : g_bad_lines
      $error("tick_match_timer: N_LINES must be a power of two, at least 2");
   end

   logic [CNT_W-1:0] cnt_inc;
   logic             step;
   logic             act;

   tmr_counter #(.CNT_W(CNT_W)) u_counter (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick_en    (tick_en),
      .ld         (cnt_wr),
      .ld_val     (cnt_wdata),
      .halt_wr    (halt_wr),
      .halt_wdata (halt_wdata),
      .cnt_q      (cnt_rdata),
      .cnt_inc    (cnt_inc),
      .step       (step)
   );

   tmr_match #(.CNT_W(CNT_W), .HAS_PEND_FLAG(HAS_PEND_FLAG)) u_match (
      .clk       (clk),
      .rst_n     (rst_n),
      .step      (step),
      .cnt_inc   (cnt_inc),
      .cmp_wr    (cmp_wr),
      .cmp_wdata (cmp_wdata),
      .act_q     (act),
      .pend_o    (pend_rdata)
   );

   tmr_route #(.N_LINES(N_LINES), .SEL_W(SEL_W)) u_route (
      .clk       (clk),
      .rst_n     (rst_n),
      .sel_wr    (sel_wr),
      .sel_wdata (sel_wdata),
      .act       (act),
      .lines     (irq_lines)
   );

   assert_no_raise_on_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $past(cnt_wr) && !$past(|irq_lines) |-> !(|irq_lines));
endmodule

// File: tb/tick_match_timer_tb.sv
module tick_match_timer_tb;
   localparam int unsigned W = 32;
   localparam int unsigned NL = 8;
   localparam int unsigned SW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          tick_en = 0, cnt_wr = 0, cmp_wr = 0, halt_wr = 0, halt_wdata = 0, sel_wr = 0;
   logic [W-1:0]  cnt_wdata = '0, cmp_wdata = '0;
   logic [SW-1:0] sel_wdata = '0;
   logic [W-1:0]  cnt_rdata, cnt_b;
   logic          pend_rdata, pend_b;
   logic [NL-1:0] irq_lines, irq_b;

   int unsigned vecs = 0;
   int unsigned errs = 0;
   bit          done = 0;

   // reference state
   logic [W-1:0]  m_cnt = '0, m_cmp = '0;
   logic          m_halt = 0, m_act = 0;
   logic [SW-1:0] m_sel = '0;

   always #5 clk = ~clk;

   tick_match_timer #(.CNT_W(W), .N_LINES(NL), .HAS_PEND_FLAG(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
      .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata), .halt_wr(halt_wr), .halt_wdata(halt_wdata),
      .sel_wr(sel_wr), .sel_wdata(sel_wdata), .cnt_rdata(cnt_rdata), .pend_rdata(pend_rdata),
      .irq_lines(irq_lines));

   tick_match_timer #(.CNT_W(W), .N_LINES(NL), .HAS_PEND_FLAG(1'b0)) u_dut_nopend (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
      .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata), .halt_wr(halt_wr), .halt_wdata(halt_wdata),
      .sel_wr(sel_wr), .sel_wdata(sel_wdata), .cnt_rdata(cnt_b), .pend_rdata(pend_b),
      .irq_lines(irq_b));

   function automatic logic [NL-1:0] exp_lines(input logic act, input logic [SW-1:0] sel);
      return act ? (NL'(1) << sel) : '0;
   endfunction

   function automatic logic exp_hit(input logic tk, input logic hlt, input logic ld,
                                    input logic [W-1:0] c, input logic [W-1:0] cmp);
      return tk && !hlt && !ld && ((c + 1) == cmp);
   endfunction

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      vecs++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // advance reference on the rising edge using the inputs driven before it
   task automatic model_edge();
      logic hit;
      hit = exp_hit(tick_en, m_halt, cnt_wr, m_cnt, m_cmp);
      if (cnt_wr) m_cnt = cnt_wdata;
      else if (tick_en && !m_halt) m_cnt = m_cnt + 1;
      if (cmp_wr) begin m_cmp = cmp_wdata; m_act = 0; end
      else if (hit) m_act = 1;
      if (halt_wr) m_halt = halt_wdata;
      if (sel_wr) m_sel = sel_wdata;
   endtask

   task automatic step_check();
      @(posedge clk);
      model_edge();
      @(negedge clk);
      check("R2/R3/R4 count", 64'(cnt_rdata), 64'(m_cnt));
      check("R5/R6/R7/R8 lines", 64'(irq_lines), 64'(exp_lines(m_act, m_sel)));
      check("R5/R7 pending", 64'(pend_rdata), 64'(m_act));
      check("R9 no flag", 64'(pend_b), 64'(0));
      check("R9 same lines", 64'(irq_b), 64'(irq_lines));
      tick_en = 0; cnt_wr = 0; cmp_wr = 0; halt_wr = 0; sel_wr = 0;
   endtask

   task automatic wr_cnt(input logic [W-1:0] v);
      cnt_wr = 1; cnt_wdata = v; step_check();
   endtask
   task automatic wr_cmp(input logic [W-1:0] v);
      cmp_wr = 1; cmp_wdata = v; step_check();
   endtask
   task automatic wr_halt(input logic v);
      halt_wr = 1; halt_wdata = v; step_check();
   endtask
   task automatic wr_sel(input logic [SW-1:0] v);
      sel_wr = 1; sel_wdata = v; step_check();
   endtask
   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin tick_en = 1; step_check(); end
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         errs++;
         $display("FAIL R1 watchdog: actual hung expected finish");
         $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
         $finish;
      end
   end

   initial begin : main
      int unsigned r;
      r = $urandom(32'd2024);
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 count", 64'(cnt_rdata), 64'(0));
      check("R1 pending", 64'(pend_rdata), 64'(0));
      check("R1 lines", 64'(irq_lines), 64'(0));
      rst_n = 1;
      @(negedge clk);

      // R5 basic match on line 0, then R6 held
      wr_cmp(32'd4);
      ticks(4);
      check("R5 match raised", 64'(irq_lines), 64'(1));
      ticks(3);
      check("R6 held", 64'(pend_rdata), 64'(1));
      // R8 move line
      wr_sel(3'd5);
      check("R8 moved", 64'(irq_lines), 64'(8'h20));
      // R7 ack
      wr_cmp(32'd20);
      check("R7 ack", 64'(irq_lines), 64'(0));

      // R4 count write equal to compare does not fire
      wr_cnt(32'd20);
      check("R4 load no match", 64'(pend_rdata), 64'(0));
      ticks(2);
      check("R4 counts from load", 64'(cnt_rdata), 64'(22));

      // R7 ack collides with match
      wr_cnt(32'd29);
      wr_cmp(32'd30);
      tick_en = 1; cmp_wr = 1; cmp_wdata = 32'd100; step_check();
      check("R7 ack wins", 64'(pend_rdata), 64'(0));

      // R3 halt blocks match
      wr_cnt(32'd98);
      wr_halt(1'b1);
      ticks(5);
      check("R3 held count", 64'(cnt_rdata), 64'(98));
      check("R3 no match", 64'(pend_rdata), 64'(0));
      wr_halt(1'b0);
      ticks(2);
      check("R3 resume match", 64'(pend_rdata), 64'(1));

      // R10 wrap match
      wr_cmp(32'd0);
      wr_cnt(32'hFFFF_FFFF);
      ticks(1);
      check("R10 wrap count", 64'(cnt_rdata), 64'(0));
      check("R10 wrap match", 64'(irq_lines), 64'(8'h20));
      wr_cmp(32'd7);

      // constrained random
      for (int n = 0; n < 3000; n++) begin
         tick_en = ($urandom % 10) < 7;
         cnt_wr  = ($urandom % 40) == 0;
         cnt_wdata = ($urandom % 8 == 0) ? $urandom : m_cmp - ($urandom % 6);
         cmp_wr  = ($urandom % 25) == 0;
         cmp_wdata = m_cnt + ($urandom % 12);
         halt_wr = ($urandom % 40) == 0;
         halt_wdata = ($urandom % 3) == 0;
         sel_wr  = ($urandom % 20) == 0;
         sel_wdata = SW'($urandom);
         step_check();
      end

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
   end
endmodule